// File: doc/BRIEF.md
# Registered Parity Bus Transceiver

This block sits between two 18-bit ports, A and B, and moves data in both directions at once. Each port is split into two lanes of nine bits: eight data bits and one parity bit. Data passes through without inversion. Each direction has its own storage stage with its own clock, latch-enable and per-lane clock-enable. The stage can let data flow straight through, load it on a rising clock edge, or hold what it has.

A shared parity control selects between two behaviours. In feed-through operation, the stored parity bits are forwarded unchanged. In checking operation, each outgoing parity bit is regenerated from the stored data using a selectable odd or even sense, and the parity of every incoming lane is checked. A mismatch drives an active-low error flag on the receiving side. Port outputs are a data vector plus a valid enable, one pair for each direction, and each pair is gated by an active-low output enable.

Reset is asynchronous and active low. Inside each clock domain it is released synchronously through a two-flop synchroniser. Storage therefore starts loading on the third rising edge after `rst_n` goes high.

Top module: `parity_xcvr`

## Requirements
- R1: While `rst_n` is low, all stored lanes read zero and both error flags read 1. Storage loads only from the third rising edge of its direction's clock after `rst_n` goes high.
- R2: Lane layout on every 18-bit vector: lane L uses bits [9L+7:9L] as data and bit 9L+8 as parity. While a direction's latch-enable is 1, its output data equals its input in the same cycle, and the stage also loads the input on each rising edge.
- R3: While latch-enable is 0 and a lane's clock-enable is 0 (active low), that lane loads its input on the rising clock edge. After the edge it shows that value even if the input changes.
- R4: While latch-enable is 0 and a lane's clock-enable is 1, the lane keeps its stored value across clock edges. Each lane is controlled by its own clock-enable.
- R5: With `par_off`=1, each output parity bit is the stored (or, when transparent, incoming) parity bit unchanged, and both error flags read 1.
- R6: With `par_off`=0, each output parity bit is regenerated from the lane's output data. With `odd_sel`=1 the nine output bits contain an odd number of ones; with `odd_sel`=0 they contain an even number.
- R7: The error flags are registered. After a rising edge of a direction's clock at which any input lane had a nine-bit ones count that does not match the parity sense, that direction's flag reads 0. The A-to-B direction reports on `err_b_n` and the B-to-A direction on `err_a_n`.
- R8: An output enable is active low. The output valid equals the inverse of the output enable, and the output data is all zero while the output enable is 1.
- R9: The two directions are independent. The controls and clock of one direction never change the storage or outputs of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Clock for the A-to-B storage stage and error flag |
| clk_ba | input | 1 | Clock for the B-to-A storage stage and error flag |
| rst_n | input | 1 | Asynchronous active-low reset |
| le_ab | input | 1 | A-to-B latch-enable, 1 = transparent |
| le_ba | input | 1 | B-to-A latch-enable, 1 = transparent |
| ce_ab_n | input | 2 | A-to-B per-lane clock-enables, active low |
| ce_ba_n | input | 2 | B-to-A per-lane clock-enables, active low |
| par_off | input | 1 | 1 = feed-through, 0 = parity regenerate and check |
| odd_sel | input | 1 | Parity sense, 1 = odd, 0 = even |
| oe_ab_n | input | 1 | B-side output enable, active low |
| oe_ba_n | input | 1 | A-side output enable, active low |
| a_in | input | 18 | Data and parity received on port A |
| b_in | input | 18 | Data and parity received on port B |
| b_out | output | 18 | Data and parity driven toward port B |
| b_out_en | output | 1 | Valid for b_out |
| a_out | output | 18 | Data and parity driven toward port A |
| a_out_en | output | 1 | Valid for a_out |
| err_b_n | output | 1 | Active-low parity error flag for A-to-B traffic |
| err_a_n | output | 1 | Active-low parity error flag for B-to-A traffic |

## Verification
Assertions check on every cycle that a held lane stays stable, that a loading lane takes the value its input had at the edge, and that regenerated parity always has the selected sense. They also check that a bad incoming lane pulls its error flag low on the following cycle. The bench's scenarios are needed to show the combinational path through a transparent stage, how reset release is sequenced through the synchroniser, and zero output while an enable is off. They also show that activity in one direction leaves the other direction untouched, which the bench demonstrates by comparing against its reference model while the two directions run in different modes.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    ST_FLOW = 2'd0,
    ST_LOAD = 2'd1,
    ST_KEEP = 2'd2
  } store_mode_e;

  function automatic store_mode_e store_mode(input logic le, input logic ce_n);
    if (le)
      return ST_FLOW;
    else if (!ce_n)
      return ST_LOAD;
    else
      return ST_KEEP;
  endfunction

endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_nxt;

  always_comb begin
    sr_nxt = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i)
      sr_q <= '0;
    else
      sr_q <= sr_nxt;
  end

  assign rst_n_o = sr_q[STAGES-1];

endmodule

// File: rtl/xcvr_lane_store.sv
module xcvr_lane_store
  import xcvr_pkg::*;
#(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         le_i,
  input  logic         ce_n_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  store_mode_e  mode;
  logic         ld_en;
  logic [W-1:0] q_nxt;
  logic [W-1:0] q_r;

  always_comb begin
    mode  = store_mode(le_i, ce_n_i);
    ld_en = (mode != ST_KEEP);
    q_nxt = d_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)
      q_r <= '0;
    else if (ld_en)
      q_r <= q_nxt;
  end

  assign q_o = (mode == ST_FLOW) ? d_i : q_r;

  // R4: a held lane does not move
  a_r4_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!le_i && ce_n_i) |=> $stable(q_r));

  // R3: a loading lane shows what its input had at the edge
  a_r3_load_value: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (le_i || !ce_n_i) |=> (q_r == $past(d_i)));

endmodule

// File: rtl/xcvr_dir.sv
module xcvr_dir #(
  parameter int LANES  = 2,
  parameter int DATA_W = 8,
  localparam int LW    = DATA_W + 1,
  localparam int BW    = LANES * LW
) (
  input  logic             clk_i,
  input  logic             arst_n_i,
  input  logic             le_i,
  input  logic [LANES-1:0] ce_n_i,
  input  logic             par_off_i,
  input  logic             odd_i,
  input  logic             oe_n_i,
  input  logic [BW-1:0]    d_i,
  output logic [BW-1:0]    q_o,
  output logic             q_en_o,
  output logic             err_n_o
);

  logic             rst_s;
  logic [BW-1:0]    st;
  logic [BW-1:0]    lane_out;
  logic [LANES-1:0] bad;
  logic             err_nxt;
  logic             err_q;

  xcvr_rst_sync #(.STAGES(2)) u_rsync (
    .clk_i    (clk_i),
    .arst_n_i (arst_n_i),
    .rst_n_o  (rst_s)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    xcvr_lane_store #(.W(LW)) u_store (
      .clk_i   (clk_i),
      .rst_n_i (rst_s),
      .le_i    (le_i),
      .ce_n_i  (ce_n_i[g]),
      .d_i     (d_i[g*LW +: LW]),
      .q_o     (st[g*LW +: LW])
    );

    // R7: a bad incoming lane pulls the flag low one cycle later
    a_r7_err_flag: assert property (@(posedge clk_i) disable iff (!rst_s)
      (!par_off_i && $past(rst_s) &&
       ($past(^d_i[g*LW +: LW]) != $past(odd_i))) |-> !err_n_o);
  end

  // parity regeneration on the outgoing side
  always_comb begin
    lane_out = st;
    if (!par_off_i) begin
      for (int l = 0; l < LANES; l++) begin
        lane_out[l*LW + DATA_W] = (^st[l*LW +: DATA_W]) ^ odd_i;
      end
    end
    if (rst_s && !par_off_i) begin
      for (int l = 0; l < LANES; l++) begin
        a_r6_regen_sense: assert ((^lane_out[l*LW +: LW]) == odd_i)
          else $error("regenerated parity has wrong sense on lane %0d", l);
      end
    end
  end

  // parity check on the incoming side
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      bad[l] = ((^d_i[l*LW +: LW]) != odd_i);
    end
    err_nxt = ~|bad;
  end

  always_ff @(posedge clk_i or negedge rst_s) begin
    if (!rst_s)
      err_q <= 1'b1;
    else
      err_q <= err_nxt;
  end

  assign err_n_o = par_off_i | err_q;
  assign q_en_o  = ~oe_n_i;
  assign q_o     = q_en_o ? lane_out : '0;

endmodule

// File: rtl/parity_xcvr.sv
module parity_xcvr #(
  parameter int LANES  = 2,
  parameter int DATA_W = 8,
  localparam int BW    = LANES * (DATA_W + 1)
) (
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic             rst_n,
  input  logic             le_ab,
  input  logic             le_ba,
  input  logic [LANES-1:0] ce_ab_n,
  input  logic [LANES-1:0] ce_ba_n,
  input  logic             par_off,
  input  logic             odd_sel,
  input  logic             oe_ab_n,
  input  logic             oe_ba_n,
  input  logic [BW-1:0]    a_in,
  input  logic [BW-1:0]    b_in,
  output logic [BW-1:0]    b_out,
  output logic             b_out_en,
  output logic [BW-1:0]    a_out,
  output logic             a_out_en,
  output logic             err_b_n,
  output logic             err_a_n
);

  xcvr_dir #(.LANES(LANES), .DATA_W(DATA_W)) u_ab (
    .clk_i     (clk_ab),
    .arst_n_i  (rst_n),
    .le_i      (le_ab),
    .ce_n_i    (ce_ab_n),
    .par_off_i (par_off),
    .odd_i     (odd_sel),
    .oe_n_i    (oe_ab_n),
    .d_i       (a_in),
    .q_o       (b_out),
    .q_en_o    (b_out_en),
    .err_n_o   (err_b_n)
  );

  xcvr_dir #(.LANES(LANES), .DATA_W(DATA_W)) u_ba (
    .clk_i     (clk_ba),
    .arst_n_i  (rst_n),
    .le_i      (le_ba),
    .ce_n_i    (ce_ba_n),
    .par_off_i (par_off),
    .odd_i     (odd_sel),
    .oe_n_i    (oe_ba_n),
    .d_i       (b_in),
    .q_o       (a_out),
    .q_en_o    (a_out_en),
    .err_n_o   (err_a_n)
  );

endmodule

// File: tb/parity_xcvr_test.sv
module parity_xcvr_test;

  localparam int CLK_PERIOD = 10;
  localparam int LANES = 2;
  localparam int DW    = 8;
  localparam int LW    = DW + 1;
  localparam int BW    = LANES * LW;

  logic             clk;
  logic             rst_n;
  logic             le_ab, le_ba;
  logic [LANES-1:0] ce_ab_n, ce_ba_n;
  logic             par_off, odd_sel;
  logic             oe_ab_n, oe_ba_n;
  logic [BW-1:0]    a_in, b_in;
  logic [BW-1:0]    b_out, a_out;
  logic             b_out_en, a_out_en, err_b_n, err_a_n;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference model state
  logic [BW-1:0] m_ab, m_ba;
  logic          m_err_ab, m_err_ba;
  int            sync_cnt;
  logic [BW-1:0] dmask, pmask;

  parity_xcvr uut (
    .clk_ab (clk), .clk_ba (clk), .rst_n (rst_n),
    .le_ab (le_ab), .le_ba (le_ba), .ce_ab_n (ce_ab_n), .ce_ba_n (ce_ba_n),
    .par_off (par_off), .odd_sel (odd_sel), .oe_ab_n (oe_ab_n), .oe_ba_n (oe_ba_n),
    .a_in (a_in), .b_in (b_in), .b_out (b_out), .b_out_en (b_out_en),
    .a_out (a_out), .a_out_en (a_out_en), .err_b_n (err_b_n), .err_a_n (err_a_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ones(input logic [BW-1:0] v, input int lo, input int n);
    int c = 0;
    for (int i = 0; i < n; i++) if (v[lo+i]) c++;
    return c;
  endfunction

  function automatic logic [BW-1:0] m_out(input logic [BW-1:0] st, input logic [BW-1:0] din,
                                          input logic le, input logic oe_n);
    logic [BW-1:0] r;
    r = le ? din : st;
    if (!par_off) begin
      for (int l = 0; l < LANES; l++) begin
        int c;
        c = ones(r, l*LW, DW);
        r[l*LW+DW] = (c % 2 == 1) ? !odd_sel : odd_sel;
      end
    end
    if (oe_n) r = '0;
    return r;
  endfunction

  function automatic logic m_bad(input logic [BW-1:0] v);
    logic b = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      int c;
      c = ones(v, l*LW, LW);
      if ((c % 2 == 1) != (odd_sel == 1'b1)) b = 1'b1;
    end
    return b;
  endfunction

  task automatic check(input logic [BW-1:0] act, input logic [BW-1:0] exp, input string tag,
                       input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tb_, input string ta_);
    logic [BW-1:0] eb, ea;
    eb = m_out(m_ab, a_in, le_ab, oe_ab_n);
    ea = m_out(m_ba, b_in, le_ba, oe_ba_n);
    check(b_out & dmask, eb & dmask, (tb_ != "") ? tb_ : (le_ab ? "R2" : "R4"), "b_out data");
    check(a_out & dmask, ea & dmask, (ta_ != "") ? ta_ : (le_ba ? "R2" : "R4"), "a_out data");
    check(b_out & pmask, eb & pmask, par_off ? "R5" : "R6", "b_out parity");
    check(a_out & pmask, ea & pmask, par_off ? "R5" : "R6", "a_out parity");
    check(BW'(b_out_en), BW'(!oe_ab_n), "R8", "b_out_en");
    check(BW'(a_out_en), BW'(!oe_ba_n), "R8", "a_out_en");
    check(BW'(err_b_n), BW'(par_off ? 1'b1 : m_err_ab), par_off ? "R5" : "R7", "err_b_n");
    check(BW'(err_a_n), BW'(par_off ? 1'b1 : m_err_ba), par_off ? "R5" : "R7", "err_a_n");
  endtask

  task automatic model_edge();
    if (!rst_n) begin
      sync_cnt = 0;
      return;
    end
    if (sync_cnt >= 2) begin
      for (int l = 0; l < LANES; l++) begin
        if (le_ab || !ce_ab_n[l]) m_ab[l*LW +: LW] = a_in[l*LW +: LW];
        if (le_ba || !ce_ba_n[l]) m_ba[l*LW +: LW] = b_in[l*LW +: LW];
      end
      m_err_ab = !m_bad(a_in);
      m_err_ba = !m_bad(b_in);
    end
    if (sync_cnt < 2) sync_cnt++;
  endtask

  task automatic cyc(input string tb_, input string ta_);
    @(negedge clk);
    compare(tb_, ta_);
    @(posedge clk);
    model_edge();
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_ab = '0; m_ba = '0; m_err_ab = 1'b1; m_err_ba = 1'b1; sync_cnt = 0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    for (int l = 0; l < LANES; l++) begin
      dmask[l*LW +: LW] = {1'b0, {DW{1'b1}}};
      pmask[l*LW +: LW] = {1'b1, {DW{1'b0}}};
    end
    le_ab = 0; le_ba = 0; ce_ab_n = '1; ce_ba_n = '1;
    par_off = 1; odd_sel = 1; oe_ab_n = 0; oe_ba_n = 0;
    a_in = 18'h3ffff; b_in = 18'h15555;
    do_reset();
    // R1: reset clears storage, flags inactive
    cyc("R1", "R1");
    par_off = 0;
    cyc("R1", "R1");
    rst_n = 1'b1;
    le_ab = 0; ce_ab_n = '0; ce_ba_n = '0;
    // loads are suppressed until the synchroniser releases (R1)
    cyc("R1", "R1");
    cyc("R1", "R1");
    cyc("", "");

    // R3: capture then change input; R9: B-to-A transparent meanwhile
    par_off = 1; le_ab = 0; ce_ab_n = '0; a_in = 18'h2a5c3;
    le_ba = 1; b_in = 18'h01234;
    cyc("", "R9");
    ce_ab_n = '1; a_in = 18'h1f0f0; b_in = 18'h3cccc;
    cyc("R3", "R9");
    // R4: lane 0 loads, lane 1 holds
    ce_ab_n = 2'b10; a_in = 18'h0ffff;
    cyc("R4", "R9");
    cyc("R4", "R9");
    // R2: transparent A-to-B, B-to-A now holding
    le_ab = 1; le_ba = 0; ce_ba_n = '1; a_in = 18'h155aa;
    cyc("R2", "R9");
    a_in = 18'h2aa55;
    cyc("R2", "R9");
    // R6 / R7: parity regenerate and check, both senses
    par_off = 0;
    for (int s = 0; s < 2; s++) begin
      odd_sel = s[0];
      a_in = 18'h00001; b_in = 18'h00100;
      cyc("", "");
      cyc("R7", "R7");
    end
    // R8: outputs disabled
    oe_ab_n = 1; oe_ba_n = 1;
    cyc("R8", "R8");
    oe_ab_n = 0; oe_ba_n = 0;
    cyc("", "");

    // random phase, compared on every clock
    for (int i = 0; i < 3000; i++) begin
      le_ab   = ($urandom_range(3) == 0);
      le_ba   = ($urandom_range(3) == 0);
      ce_ab_n = LANES'($urandom);
      ce_ba_n = LANES'($urandom);
      par_off = ($urandom_range(9) < 3);
      odd_sel = 1'($urandom);
      oe_ab_n = ($urandom_range(4) == 0);
      oe_ba_n = ($urandom_range(4) == 0);
      a_in    = BW'($urandom);
      b_in    = BW'($urandom);
      if (i == 1500) do_reset();
      if (i == 1503) rst_n = 1'b1;
      cyc("", "");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule